// File: doc/BRIEF.md
# Inter-Processor Interrupt Dispatcher

This block turns a 64-bit interrupt command into a stream of per-processor delivery requests for a cluster of up to `N_CPU` processors. The command is presented as two 32-bit halves. The upper half carries the numeric destination processor. A write strobe on the lower half starts the command. The lower half carries the vector, the delivery mode and a destination shorthand. The shorthand picks one of four target sets: the explicit destination, the local processor only, every active processor, or every active processor except the local one.

Fixed-mode and non-maskable commands load their target set into a pending register. That register is drained lowest processor index first, one processor per accepted valid/ready handshake. A startup command adds its destination to the active-processor mask that the block holds, and it delivers nothing. Any other delivery mode raises a one-cycle `unhandled` pulse so that outside logic can deal with it. While the pending set is not empty, `busy` is high and any new command write is dropped.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset, `dlv_valid`, `busy` and `unhandled` are 0, and `active_mask` equals the parameter `BOOT_MASK`.
- R2: A fixed-mode command (`cmd_lo[10:8]` = 000) delivers `cmd_lo[7:0]` on `dlv_vector` to each selected processor, with `dlv_nmi` = 0.
- R3: A non-maskable command (`cmd_lo[10:8]` = 100) delivers to each selected processor with `dlv_nmi` = 1.
- R4: Shorthand `cmd_lo[19:18]` = 00 selects the processor whose number is in `cmd_hi`, whether or not it is active. A value of `N_CPU` or more selects no processor, and nothing is delivered.
- R5: Shorthand 01 selects only the processor `self_id`.
- R6: Shorthand 10 selects every processor whose `active_mask` bit is set, `self_id` included.
- R7: Shorthand 11 selects every active processor except `self_id`.
- R8: Selected processors are presented on `dlv_cpu` in strictly ascending index order. Each one is removed from the pending set on the cycle where `dlv_valid` and `dlv_ready` are both high. While `dlv_ready` is low, the presented processor and vector stay unchanged.
- R9: A startup command (`cmd_lo[10:8]` = 110) sets bit `cmd_hi` of `active_mask` when `cmd_hi` < `N_CPU`, and it produces no delivery.
- R10: Any other mode value produces no delivery. Instead, `unhandled` is high for exactly the one cycle after the write.
- R11: While `busy` is high, a command write has no effect: it adds no deliveries, does not change `active_mask`, and raises no `unhandled` pulse.
- R12: `dlv_valid` goes high in the cycle right after an accepted fixed or non-maskable write whose target set is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_id | input | IDX_W | Index of the local processor |
| cmd_wr | input | 1 | Strobe for the lower-half command write |
| cmd_lo | input | 32 | Lower command half: vector, mode, shorthand |
| cmd_hi | input | 32 | Upper command half: destination processor number |
| dlv_valid | output | 1 | A delivery request is presented |
| dlv_ready | input | 1 | The receiver accepts the presented request |
| dlv_cpu | output | IDX_W | Target processor of the presented request |
| dlv_vector | output | 8 | Vector to deliver |
| dlv_nmi | output | 1 | The request is a non-maskable interrupt |
| busy | output | 1 | The pending set is not empty |
| unhandled | output | 1 | One-cycle pulse for an unsupported delivery mode |
| active_mask | output | N_CPU | Active-processor mask |

## Verification
The command table first activates three sparse processors through startup writes. It then fires every shorthand against the same active mask, with the local index set to an active processor. This makes the including and excluding cases differ by exactly one bit, and it makes an explicit target on an inactive processor differ from one filtered by the mask. The non-maskable writes reuse the same target sets, so only the `dlv_nmi` flag separates them from fixed writes. Out-of-range destinations and two unsupported modes show that nothing is delivered and that a pulse occurs. Directed tests hold `dlv_ready` low part-way through a broadcast to expose any drift in order or vector, and they issue writes while `busy` is high to show that such writes leave both the delivery stream and the active mask untouched.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam logic [2:0] MODE_FIXED = 3'b000;
  localparam logic [2:0] MODE_NMI   = 3'b100;
  localparam logic [2:0] MODE_START = 3'b110;

  localparam logic [1:0] SH_DEST   = 2'b00;
  localparam logic [1:0] SH_SELF   = 2'b01;
  localparam logic [1:0] SH_ALL    = 2'b10;
  localparam logic [1:0] SH_OTHERS = 2'b11;

  typedef enum logic [1:0] {
    K_FIXED = 2'd0,
    K_NMI   = 2'd1,
    K_START = 2'd2,
    K_OTHER = 2'd3
  } cmd_kind_e;

  function automatic logic [2:0] mode_of(input logic [31:0] lo);
    return lo[10:8];
  endfunction

  function automatic logic [1:0] shorthand_of(input logic [31:0] lo);
    return lo[19:18];
  endfunction

  function automatic cmd_kind_e kind_of(input logic [2:0] mode);
    case (mode)
      MODE_FIXED: return K_FIXED;
      MODE_NMI:   return K_NMI;
      MODE_START: return K_START;
      default:    return K_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_pkg::*;
#(
  parameter int N_CPU = 8,
  localparam int IDX_W = $clog2(N_CPU)
) (
  input  logic [31:0]      cmd_lo,
  input  logic [31:0]      cmd_hi,
  input  logic [IDX_W-1:0] self_id,
  input  logic [N_CPU-1:0] active,
  output cmd_kind_e        kind,
  output logic [7:0]       vector,
  output logic [N_CPU-1:0] target_set,
  output logic [N_CPU-1:0] dest_hit
);

  logic [N_CPU-1:0] self_hit;

  // One-hot views of the destination number and the local index.
  for (genvar i = 0; i < N_CPU; i++) begin : g_hit
    assign dest_hit[i] = (cmd_hi == 32'(i));
    assign self_hit[i] = (self_id == IDX_W'(i));
  end

  assign kind   = kind_of(mode_of(cmd_lo));
  assign vector = cmd_lo[7:0];

  always_comb begin
    case (shorthand_of(cmd_lo))
      SH_DEST:   target_set = dest_hit;
      SH_SELF:   target_set = self_hit;
      SH_ALL:    target_set = active;
      default:   target_set = active & ~self_hit;
    endcase
  end

endmodule

// File: rtl/ipi_pick.sv
module ipi_pick #(
  parameter int N_CPU = 8,
  localparam int IDX_W = $clog2(N_CPU)
) (
  input  logic [N_CPU-1:0] pending,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N_CPU-1:0] onehot
);

  // Lowest set bit wins; scanned from the top so the last hit is the lowest.
  function automatic logic [IDX_W-1:0] lowest_index(input logic [N_CPU-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = N_CPU - 1; k >= 0; k--) begin
      if (v[k]) r = IDX_W'(k);
    end
    return r;
  endfunction

  // Isolate the lowest set bit: v & -v.
  function automatic logic [N_CPU-1:0] lowest_bit(input logic [N_CPU-1:0] v);
    return v & (~v + N_CPU'(1));
  endfunction

  assign any    = |pending;
  assign idx    = lowest_index(pending);
  assign onehot = lowest_bit(pending);

endmodule

// File: rtl/ipi_active_reg.sv
module ipi_active_reg #(
  parameter int               N_CPU     = 8,
  parameter logic [N_CPU-1:0] BOOT_MASK = N_CPU'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [N_CPU-1:0] set_bits,
  output logic [N_CPU-1:0] active
);

  always_ff @(posedge clk) begin
    if (!rst_n)      active <= BOOT_MASK;
    else if (set_en) active <= active | set_bits;
  end

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int               N_CPU     = 8,
  parameter logic [N_CPU-1:0] BOOT_MASK = N_CPU'(1),
  localparam int              IDX_W     = $clog2(N_CPU)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] self_id,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_lo,
  input  logic [31:0]      cmd_hi,
  output logic             dlv_valid,
  input  logic             dlv_ready,
  output logic [IDX_W-1:0] dlv_cpu,
  output logic [7:0]       dlv_vector,
  output logic             dlv_nmi,
  output logic             busy,
  output logic             unhandled,
  output logic [N_CPU-1:0] active_mask
);

  cmd_kind_e        kind;
  logic [7:0]       dec_vector;
  logic [N_CPU-1:0] target_set;
  logic [N_CPU-1:0] dest_hit;
  logic [N_CPU-1:0] pending_q;
  logic [N_CPU-1:0] pick_onehot;
  logic [7:0]       vector_q;
  logic             nmi_q;
  logic             unh_q;

  // Named internal events.
  logic cmd_take, load_fire, start_fire, unh_fire, hs_fire;

  ipi_cmd_decode #(.N_CPU(N_CPU)) u_dec (
    .cmd_lo     (cmd_lo),
    .cmd_hi     (cmd_hi),
    .self_id    (self_id),
    .active     (active_mask),
    .kind       (kind),
    .vector     (dec_vector),
    .target_set (target_set),
    .dest_hit   (dest_hit)
  );

  ipi_pick #(.N_CPU(N_CPU)) u_pick (
    .pending (pending_q),
    .any     (busy),
    .idx     (dlv_cpu),
    .onehot  (pick_onehot)
  );

  ipi_active_reg #(.N_CPU(N_CPU), .BOOT_MASK(BOOT_MASK)) u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (start_fire),
    .set_bits (dest_hit),
    .active   (active_mask)
  );

  assign cmd_take   = cmd_wr & ~busy;
  assign load_fire  = cmd_take & ((kind == K_FIXED) | (kind == K_NMI));
  assign start_fire = cmd_take & (kind == K_START);
  assign unh_fire   = cmd_take & (kind == K_OTHER);
  assign hs_fire    = dlv_valid & dlv_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= '0;
      vector_q  <= '0;
      nmi_q     <= 1'b0;
      unh_q     <= 1'b0;
    end else begin
      unh_q <= unh_fire;
      if (load_fire) begin
        pending_q <= target_set;
        vector_q  <= dec_vector;
        nmi_q     <= (kind == K_NMI);
      end else if (hs_fire) begin
        pending_q <= pending_q & ~pick_onehot;
      end
    end
  end

  assign dlv_valid  = busy;
  assign dlv_vector = vector_q;
  assign dlv_nmi    = nmi_q;
  assign unhandled  = unh_q;

endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
  parameter int  N_CPU = 8,
  localparam int IDX_W = $clog2(N_CPU)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_wr,
  input logic [31:0]      cmd_lo,
  input logic [31:0]      cmd_hi,
  input logic             dlv_valid,
  input logic             dlv_ready,
  input logic [IDX_W-1:0] dlv_cpu,
  input logic [7:0]       dlv_vector,
  input logic             busy,
  input logic             unhandled,
  input logic [N_CPU-1:0] active_mask
);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_cpu) && $stable(dlv_vector)));

  p_ascending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_ready) |=> (!dlv_valid || (dlv_cpu > $past(dlv_cpu))));

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> (!unhandled && $stable(active_mask)));

  p_startup_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && cmd_lo[10:8] == 3'b110 && cmd_hi < 32'(N_CPU))
      |=> (active_mask[$past(cmd_hi[IDX_W-1:0])] && !dlv_valid));

  p_unhandled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unhandled |-> (!dlv_valid && $past(cmd_wr)));

  p_vector_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && $past(dlv_valid)) |-> $stable(dlv_vector));

endmodule

bind ipi_dispatch ipi_dispatch_chk #(.N_CPU(N_CPU)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_wr      (cmd_wr),
  .cmd_lo      (cmd_lo),
  .cmd_hi      (cmd_hi),
  .dlv_valid   (dlv_valid),
  .dlv_ready   (dlv_ready),
  .dlv_cpu     (dlv_cpu),
  .dlv_vector  (dlv_vector),
  .busy        (busy),
  .unhandled   (unhandled),
  .active_mask (active_mask)
);

// File: tb/ipi_dispatch_bench.sv
module ipi_dispatch_bench;

  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] self_id = '0;
  logic         cmd_wr = 1'b0;
  logic [31:0]  cmd_lo = '0;
  logic [31:0]  cmd_hi = '0;
  logic         dlv_ready = 1'b1;
  logic         dlv_valid, dlv_nmi, busy, unhandled;
  logic [W-1:0] dlv_cpu;
  logic [7:0]   dlv_vector;
  logic [N-1:0] active_mask;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ipi_dispatch #(.N_CPU(N), .BOOT_MASK(8'h01)) u_ipi_dispatch (
    .clk(clk), .rst_n(rst_n), .self_id(self_id), .cmd_wr(cmd_wr),
    .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .dlv_valid(dlv_valid),
    .dlv_ready(dlv_ready), .dlv_cpu(dlv_cpu), .dlv_vector(dlv_vector),
    .dlv_nmi(dlv_nmi), .busy(busy), .unhandled(unhandled),
    .active_mask(active_mask)
  );

  typedef struct packed {
    logic [31:0] lo;
    logic [31:0] hi;
    logic [2:0]  self;
    logic [7:0]  mask;
    logic        nmi;
    logic        unh;
    logic [7:0]  act;
  } row_t;

  localparam int NROW = 13;
  // lo, hi, self, expected target mask, nmi, unhandled, expected active mask
  localparam row_t ROWS [NROW] = '{
    '{32'h0000_0600, 32'd2,   3'd0, 8'h00, 1'b0, 1'b0, 8'h05}, // R9 startup 2
    '{32'h0000_0600, 32'd5,   3'd0, 8'h00, 1'b0, 1'b0, 8'h25}, // R9 startup 5
    '{32'h0000_0600, 32'd7,   3'd0, 8'h00, 1'b0, 1'b0, 8'hA5}, // R9 startup 7
    '{32'h0000_0041, 32'd3,   3'd0, 8'h08, 1'b0, 1'b0, 8'hA5}, // R4 inactive explicit
    '{32'h0004_0052, 32'd0,   3'd5, 8'h20, 1'b0, 1'b0, 8'hA5}, // R5 self
    '{32'h0008_0060, 32'd0,   3'd2, 8'hA5, 1'b0, 1'b0, 8'hA5}, // R6 all
    '{32'h000C_0061, 32'd0,   3'd2, 8'hA1, 1'b0, 1'b0, 8'hA5}, // R7 others
    '{32'h000C_0400, 32'd0,   3'd0, 8'hA4, 1'b1, 1'b0, 8'hA5}, // R3 nmi others
    '{32'h0000_0433, 32'd6,   3'd0, 8'h40, 1'b1, 1'b0, 8'hA5}, // R3 nmi explicit
    '{32'h0000_0044, 32'd9,   3'd0, 8'h00, 1'b0, 1'b0, 8'hA5}, // R4 out of range
    '{32'h0000_0100, 32'd1,   3'd0, 8'h00, 1'b0, 1'b1, 8'hA5}, // R10 mode 001
    '{32'h0000_0500, 32'd1,   3'd0, 8'h00, 1'b0, 1'b1, 8'hA5}, // R10 mode 101
    '{32'h0000_00FF, 32'd0,   3'd0, 8'h01, 1'b0, 1'b0, 8'hA5}  // R2 explicit 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [31:0] lo, input logic [31:0] hi, input logic [2:0] s);
    @(negedge clk);
    cmd_lo = lo; cmd_hi = hi; self_id = s; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  // Collect deliveries with ready high; returns the mask of processors seen.
  task automatic drain(input string req, input logic [7:0] vec, input logic nmi,
                       output logic [7:0] got);
    int last;
    got = '0;
    last = -1;
    for (int c = 0; c < N + 2; c++) begin
      if (dlv_valid) begin
        if (int'(dlv_cpu) <= last) chk({req, " R8 order"}, 32'(dlv_cpu), 32'(last + 1));
        last = int'(dlv_cpu);
        got[dlv_cpu] = 1'b1;
        chk({req, " R2 vector"}, 32'(dlv_vector), 32'(vec));
        chk({req, " R3 nmi flag"}, 32'(dlv_nmi), 32'(nmi));
      end
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", 32'(dlv_valid), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 unhandled", 32'(unhandled), 0);
    chk("R1 active", 32'(active_mask), 32'h01);

    for (int r = 0; r < NROW; r++) begin
      write_cmd(ROWS[r].lo, ROWS[r].hi, ROWS[r].self);
      chk($sformatf("R12 row%0d valid", r), 32'(dlv_valid), 32'(ROWS[r].mask != 0));
      chk($sformatf("R10 row%0d pulse", r), 32'(unhandled), 32'(ROWS[r].unh));
      drain($sformatf("row%0d", r), ROWS[r].lo[7:0], ROWS[r].nmi, got);
      chk($sformatf("R4 R5 R6 R7 row%0d targets", r), 32'(got), 32'(ROWS[r].mask));
      chk($sformatf("R10 row%0d pulse end", r), 32'(unhandled), 0);
      chk($sformatf("R9 row%0d active", r), 32'(active_mask), 32'(ROWS[r].act));
    end

    // R8: stall with ready low in the middle of a broadcast.
    dlv_ready = 1'b0;
    write_cmd(32'h0008_0077, 32'd0, 3'd0);
    for (int c = 0; c < 3; c++) begin
      chk("R8 stall valid", 32'(dlv_valid), 1);
      chk("R8 stall cpu", 32'(dlv_cpu), 0);
      chk("R8 stall vector", 32'(dlv_vector), 32'h77);
      @(negedge clk);
    end
    dlv_ready = 1'b1;
    @(negedge clk);
    chk("R8 advance cpu", 32'(dlv_cpu), 2);
    dlv_ready = 1'b0;

    // R11: writes while busy are dropped (startup 3, unsupported mode, self fixed).
    write_cmd(32'h0000_0600, 32'd3, 3'd0);
    chk("R11 active unchanged", 32'(active_mask), 32'hA5);
    write_cmd(32'h0000_0100, 32'd0, 3'd0);
    chk("R11 no pulse", 32'(unhandled), 0);
    write_cmd(32'h0004_0011, 32'd0, 3'd1);
    chk("R11 cpu still 2", 32'(dlv_cpu), 2);
    dlv_ready = 1'b1;
    drain("R11 tail", 8'h77, 1'b0, got);
    chk("R11 remaining targets", 32'(got), 32'hA4);
    chk("R11 idle after", 32'(busy), 0);
    chk("R11 active final", 32'(active_mask), 32'hA5);

    // R4: destination number with high bits set selects nobody.
    write_cmd(32'h0000_0012, 32'h0000_0102, 3'd0);
    chk("R4 high dest no valid", 32'(dlv_valid), 0);

    finish_run();
  end

endmodule